// File: doc/BRIEF.md
# Split-Phase Dickson Gate Sequencer

This block drives the eight power switches of a 4-to-1 Dickson switched-capacitor stage from a free-running counter, with no feedback. One switching period is a programmed number of clock cycles. The block runs in one of two modes. In two-phase mode, two equal halves alternate. In split-phase mode, four sub-phases run in a selectable order, and their lengths stand in the ratio 3:1:3:1. The short sub-phases act as buffers so that the flying capacitors reach matching voltages before the full configuration connects.

The switches form two groups. The odd-numbered group drives while the second-phase signal is active, and the even-numbered group drives while the first-phase signal is active. A programmable dead time blanks every output whenever conduction passes from one group to the other. Changes to the mode, order, period and dead time are taken only at a period boundary. With a 100 MHz clock, period counts from 200 to 2000 cycles give 500 kHz down to 50 kHz.

Top module: `dickson_gate_seq`

## Requirements
- R1: While reset is low, all eight switch outputs and the sub-phase code are zero. After release, the first sub-phase of the selected order begins on the first clock edge.
- R2: With `split_mode` low, the period has two halves of 4u cycles each, where u is the sub-phase unit defined in R8. The first half drives S2, S4, S6 and S8 with code 00, and the second half drives S1, S3, S5 and S7 with code 10.
- R3: With `split_mode` high, sub-phases 1a (code 00) and 2a (code 10) each last 3u cycles, and 1b (code 01) and 2b (code 11) each last u cycles.
- R4: In split mode, S2, S4 and S6 are on through 1a and 1b, and S1, S3 and S7 are on through 2a and 2b. S8 is on only in 1a, and S5 only in 2a.
- R5: Order select 0 gives 1b, 1a, 2b, 2a. Order select 3 behaves the same as 0.
- R6: Order select 1 gives the reverse order: 2a, 2b, 1a, 1b.
- R7: Order select 2 gives 1a, 2a, 1b, 2b.
- R8: The unit u is the period count divided by 8 with the remainder dropped, and a result of 0 is raised to 1.
- R9: When a sub-phase's group differs from that of the previous sub-phase, all outputs stay low for its first D cycles. This includes the first sub-phase after reset and the wrap from one period to the next. At a boundary inside one group there is no blanking. D must be shorter than u.
- R10: Mode, order, period and dead-time inputs take effect only at a period start. A change made in mid-period leaves the rest of that period unchanged.
- R11: A switch of the S2/S4/S6/S8 group is never on in the same cycle as a switch of the S1/S3/S5/S7 group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_len | input | CNT_W | Switching period in clock cycles (multiple of 8) |
| split_mode | input | 1 | 1 = four sub-phases, 0 = two halves |
| seq_sel | input | 2 | Sub-phase order select |
| dead_time | input | DT_W | Blanking cycles at a group change |
| sw | output | 8 | Switch enables, bit 0 = S1 ... bit 7 = S8 |
| subphase | output | 2 | Current sub-phase: bit 1 = second group, bit 0 = short sub-phase |

## Verification
The assertions check on every cycle that the two switch groups never conduct together, and that a group change with a nonzero dead time always passes through an all-off cycle. They also check that S8 and S5 appear only in their long sub-phases, that two-phase mode never shows a short sub-phase, that the counter stays inside the sub-phase length, and that the latched settings hold between period starts. Some properties need a whole period to show: the exact sub-phase lengths, the three orders, the rounding of odd period counts, and the deferral of a mid-period mode change. Only the bench's reference timeline, compared cycle by cycle across its scenarios, covers these.

// File: rtl/dgs_pkg.sv
package dgs_pkg;

  // Sub-phase code: bit 1 selects the second switch group, bit 0 marks a short buffer sub-phase
  localparam logic [1:0] SP_1A = 2'b00;
  localparam logic [1:0] SP_1B = 2'b01;
  localparam logic [1:0] SP_2A = 2'b10;
  localparam logic [1:0] SP_2B = 2'b11;

  // Bit k of the switch vector is switch S(k+1)
  localparam logic [7:0] GRP_A_MASK = 8'b1010_1010; // S2 S4 S6 S8
  localparam logic [7:0] GRP_B_MASK = 8'b0101_0101; // S1 S3 S5 S7

  function automatic logic [1:0] slot_sub(input logic split, input logic [1:0] ord,
                                          input logic [1:0] slot);
    logic [1:0] r;
    if (!split) begin
      r = slot[0] ? SP_2A : SP_1A;
    end else begin
      case (ord)
        2'd1: case (slot)
                2'd0: r = SP_2A; 2'd1: r = SP_2B; 2'd2: r = SP_1A; default: r = SP_1B;
              endcase
        2'd2: case (slot)
                2'd0: r = SP_1A; 2'd1: r = SP_2A; 2'd2: r = SP_1B; default: r = SP_2B;
              endcase
        default: case (slot)
                2'd0: r = SP_1B; 2'd1: r = SP_1A; 2'd2: r = SP_2B; default: r = SP_2A;
              endcase
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/dgs_phase_ctrl.sv
module dgs_phase_ctrl #(
  parameter int CNT_W = 12,
  parameter int DT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_len,
  input  logic             split_i,
  input  logic [1:0]       ord_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic [1:0]       sub_o,
  output logic             split_o,
  output logic             active_o,
  output logic             enter_o,
  output logic             chg_o,
  output logic [DT_W-1:0]  dt_val_o
);
  import dgs_pkg::*;

  localparam int SLOT_W = 2;

  logic              fresh_q, fresh_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        sub_q, sub_d;
  logic              split_q, split_d;
  logic [1:0]        ord_q, ord_d;
  logic [CNT_W-1:0]  unit_q, unit_d;
  logic [DT_W-1:0]   dt_q, dt_d;
  logic              load;
  logic              enter;
  logic [CNT_W-1:0]  slot_len;
  logic [SLOT_W-1:0] last_slot;
  logic [CNT_W-1:0]  unit_raw;

  assign unit_raw  = period_len >> 3;
  assign last_slot = split_q ? SLOT_W'(3) : SLOT_W'(1);

  always_comb begin
    if (!split_q)       slot_len = unit_q << 2;
    else if (sub_q[0])  slot_len = unit_q;
    else                slot_len = (unit_q << 1) + unit_q;
  end

  // next-state
  always_comb begin
    fresh_d = fresh_q;
    slot_d  = slot_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    enter   = 1'b0;
    if (fresh_q) begin
      fresh_d = 1'b0;
      slot_d  = '0;
      cnt_d   = '0;
      load    = 1'b1;
      enter   = 1'b1;
    end else if (cnt_q == slot_len - CNT_W'(1)) begin
      cnt_d = '0;
      enter = 1'b1;
      if (slot_q == last_slot) begin
        slot_d = '0;
        load   = 1'b1;
      end else begin
        slot_d = slot_q + SLOT_W'(1);
      end
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    split_d = load ? split_i : split_q;
    ord_d   = load ? ord_i   : ord_q;
    dt_d    = load ? dead_i  : dt_q;
    unit_d  = load ? ((unit_raw == '0) ? CNT_W'(1) : unit_raw) : unit_q;
    sub_d   = slot_sub(split_d, ord_d, slot_d);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= 1'b1;
      slot_q  <= '0;
      cnt_q   <= '0;
      sub_q   <= SP_1A;
    end else begin
      fresh_q <= fresh_d;
      slot_q  <= slot_d;
      cnt_q   <= cnt_d;
      sub_q   <= sub_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      split_q <= 1'b0;
      ord_q   <= '0;
      unit_q  <= CNT_W'(1);
      dt_q    <= '0;
    end else if (load) begin
      split_q <= split_d;
      ord_q   <= ord_d;
      unit_q  <= unit_d;
      dt_q    <= dt_d;
    end
  end

  assign sub_o    = sub_q;
  assign split_o  = split_q;
  assign active_o = ~fresh_q;
  assign enter_o  = enter;
  assign chg_o    = enter & (fresh_q | (sub_d[1] != sub_q[1]));
  assign dt_val_o = dt_d;

  // R10: latched settings move only at a period start
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> ($stable(split_q) && $stable(ord_q) && $stable(unit_q) && $stable(dt_q)));

  // R3: the position counter never leaves the current sub-phase length
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < slot_len));

endmodule

// File: rtl/dgs_dead_timer.sv
module dgs_dead_timer #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enter_i,
  input  logic            chg_i,
  input  logic [DT_W-1:0] dt_val_i,
  output logic            blank_o
);
  logic [DT_W-1:0] left_q, left_d;

  always_comb begin
    if (chg_i)               left_d = dt_val_i;
    else if (enter_i)        left_d = '0;
    else if (left_q != '0)   left_d = left_q - DT_W'(1);
    else                     left_d = left_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign blank_o = (left_q != '0);

  // R9: a group change with nonzero dead time opens with a blanked cycle
  a_r9_blank_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_i && dt_val_i != '0) |=> blank_o);

endmodule

// File: rtl/dgs_switch_map.sv
module dgs_switch_map (
  input  logic       on_i,
  input  logic       split_i,
  input  logic [1:0] sub_i,
  output logic [7:0] sw_o
);
  logic grp_a, grp_b, long_ph;

  assign grp_a   = on_i & ~sub_i[1];
  assign grp_b   = on_i &  sub_i[1];
  assign long_ph = ~split_i | ~sub_i[0];

  // leg k: bit 2k belongs to the second group, bit 2k+1 to the first
  for (genvar k = 0; k < 4; k++) begin : g_leg
    if (k == 2) begin : g_b_late
      assign sw_o[2*k] = grp_b & long_ph;
    end else begin : g_b_std
      assign sw_o[2*k] = grp_b;
    end
    if (k == 3) begin : g_a_late
      assign sw_o[2*k+1] = grp_a & long_ph;
    end else begin : g_a_std
      assign sw_o[2*k+1] = grp_a;
    end
  end

endmodule

// File: rtl/dickson_gate_seq.sv
module dickson_gate_seq #(
  parameter int CNT_W = 12,
  parameter int DT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_len,
  input  logic             split_mode,
  input  logic [1:0]       seq_sel,
  input  logic [DT_W-1:0]  dead_time,
  output logic [7:0]       sw,
  output logic [1:0]       subphase
);
  import dgs_pkg::*;

  logic            active, enter, chg, blank, split_cur;
  logic [1:0]      sub_cur;
  logic [DT_W-1:0] dt_val;

  dgs_phase_ctrl #(.CNT_W(CNT_W), .DT_W(DT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .period_len(period_len), .split_i(split_mode),
    .ord_i(seq_sel), .dead_i(dead_time), .sub_o(sub_cur), .split_o(split_cur),
    .active_o(active), .enter_o(enter), .chg_o(chg), .dt_val_o(dt_val)
  );

  dgs_dead_timer #(.DT_W(DT_W)) u_dead (
    .clk(clk), .rst_n(rst_n), .enter_i(enter), .chg_i(chg),
    .dt_val_i(dt_val), .blank_o(blank)
  );

  dgs_switch_map u_map (
    .on_i(active & ~blank), .split_i(split_cur), .sub_i(sub_cur), .sw_o(sw)
  );

  assign subphase = sub_cur;

  // R1: outputs are quiet while reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    (!rst_n) |=> (sw == 8'h00));

  // R11: the two groups never conduct together
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !((|(sw & GRP_A_MASK)) && (|(sw & GRP_B_MASK))));

  // R9: with dead time set, one group never hands straight to the other
  a_r9_gap_a_to_b: assert property (@(posedge clk) disable iff (!rst_n)
    ((dt_val != '0) && (|(sw & GRP_A_MASK))) |=> !(|(sw & GRP_B_MASK)));
  a_r9_gap_b_to_a: assert property (@(posedge clk) disable iff (!rst_n)
    ((dt_val != '0) && (|(sw & GRP_B_MASK))) |=> !(|(sw & GRP_A_MASK)));

  // R4: the delayed switches appear only in their long sub-phases
  a_r4_s8_window: assert property (@(posedge clk) disable iff (!rst_n)
    (split_cur && sw[7]) |-> (subphase == SP_1A));
  a_r4_s5_window: assert property (@(posedge clk) disable iff (!rst_n)
    (split_cur && sw[4]) |-> (subphase == SP_2A));

  // R2: two-phase mode never shows a short sub-phase
  a_r2_no_short: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_cur) |-> (subphase[0] == 1'b0));

endmodule

// File: tb/dickson_gate_seq_test.sv
module dickson_gate_seq_test;
  localparam int CW = 12;
  localparam int DW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] period_len;
  logic          split_mode;
  logic [1:0]    seq_sel;
  logic [DW-1:0] dead_time;
  logic [7:0]    sw;
  logic [1:0]    subphase;

  always #5 clk = ~clk;

  dickson_gate_seq #(.CNT_W(CW), .DT_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .period_len(period_len), .split_mode(split_mode),
    .seq_sel(seq_sel), .dead_time(dead_time), .sw(sw), .subphase(subphase)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  string tag = "R1";
  logic [7:0] q_sw[$];
  logic [1:0] q_sub[$];
  int    prev_grp = -1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] want_sw(input bit split, input logic [1:0] sub, input bit blank);
    logic [7:0] v;
    if (blank) return 8'h00;
    v = sub[1] ? 8'b0101_0101 : 8'b1010_1010;
    if (split && sub == 2'b01) v[7] = 1'b0;
    if (split && sub == 2'b11) v[4] = 1'b0;
    return v;
  endfunction

  // builds the expected timeline of one period from the settings seen at its start
  task automatic build_period();
    int u, n;
    logic [1:0] subs[4];
    int lens[4];
    u = int'(period_len) / 8;
    if (u == 0) u = 1;
    if (!split_mode) begin
      n = 2; subs[0] = 2'b00; subs[1] = 2'b10; lens[0] = 4*u; lens[1] = 4*u;
    end else begin
      n = 4;
      case (seq_sel)
        2'd1: begin subs[0]=2'b10; subs[1]=2'b11; subs[2]=2'b00; subs[3]=2'b01; end
        2'd2: begin subs[0]=2'b00; subs[1]=2'b10; subs[2]=2'b01; subs[3]=2'b11; end
        default: begin subs[0]=2'b01; subs[1]=2'b00; subs[2]=2'b11; subs[3]=2'b10; end
      endcase
      for (int i = 0; i < 4; i++) lens[i] = subs[i][0] ? u : 3*u;
    end
    for (int i = 0; i < n; i++) begin
      int d;
      int g;
      g = int'(subs[i][1]);
      d = (g != prev_grp) ? int'(dead_time) : 0;
      for (int c = 0; c < lens[i]; c++) begin
        q_sw.push_back(want_sw(split_mode, subs[i], c < d));
        q_sub.push_back(subs[i]);
      end
      prev_grp = g;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q_sw.delete(); q_sub.delete(); prev_grp = -1;
    end else if (q_sw.size() == 0) begin
      build_period();
    end
  end

  always @(negedge clk) begin
    logic [7:0] es;
    logic [1:0] eb;
    string r;
    if (q_sw.size() != 0) begin
      es = q_sw.pop_front(); eb = q_sub.pop_front(); r = tag;
    end else begin
      es = 8'h00; eb = 2'b00; r = "R1";
    end
    check(sw === es, r, int'(sw), int'(es));
    check(subphase === eb, r, int'(subphase), int'(eb));
    // R11 no overlap between groups
    check(!((|(sw & 8'hAA)) && (|(sw & 8'h55))), "R11", int'(sw), 0);
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    period_len = CW'(16); split_mode = 1'b0; seq_sel = 2'd0; dead_time = DW'(1);
    wait_cyc(3);
    // R1 reset state
    tag = "R1";
    check(sw == 8'h00, "R1", int'(sw), 0);
    check(subphase == 2'b00, "R1", int'(subphase), 0);
    rst_n = 1'b1;
    tag = "R2"; wait_cyc(48);
    tag = "R3 R4 R5"; split_mode = 1'b1; seq_sel = 2'd0; period_len = CW'(32); dead_time = DW'(2);
    wait_cyc(110);
    tag = "R6"; seq_sel = 2'd1; period_len = CW'(40); wait_cyc(130);
    tag = "R7"; seq_sel = 2'd2; period_len = CW'(24); dead_time = DW'(1); wait_cyc(80);
    tag = "R5"; seq_sel = 2'd3; wait_cyc(60);
    tag = "R8"; seq_sel = 2'd0; period_len = CW'(37); wait_cyc(100);
    tag = "R8"; period_len = CW'(5); dead_time = DW'(0); wait_cyc(30);
    tag = "R9"; period_len = CW'(32); dead_time = DW'(0); wait_cyc(70);
    tag = "R9"; dead_time = DW'(3); wait_cyc(70);
    // R10: change mode and order in mid-period
    tag = "R10"; wait_cyc(13); split_mode = 1'b0; wait_cyc(9); seq_sel = 2'd1; split_mode = 1'b1;
    wait_cyc(7); period_len = CW'(48); wait_cyc(120);
    tag = "R3"; period_len = CW'(200); seq_sel = 2'd1; dead_time = DW'(3); wait_cyc(620);
    // R1 again: reset asserted mid-run
    rst_n = 1'b0; #2;
    check(sw == 8'h00, "R1", int'(sw), 0);
    check(subphase == 2'b00, "R1", int'(subphase), 0);
    wait_cyc(3);
    split_mode = 1'b1; seq_sel = 2'd2; period_len = CW'(16); dead_time = DW'(1);
    rst_n = 1'b1;
    tag = "R1 R7"; wait_cyc(40);
    finish_run();
  end

endmodule